// File: doc/BRIEF.md
# NCO Phase and Frequency Control

This block produces the phase argument for a quadrature oscillator. The frequency word is the sum of a center frequency and an offset frequency. Each clock where the accumulator is enabled, that sum is added into a 32-bit phase accumulator. A 16-bit phase word is then added to the upper half of the accumulator, and the result is registered as the sine/cosine lookup argument. The sine/cosine table that consumes this argument lies outside this block.

A host loads words over a 16-bit bus with a 2-bit address, a chip select and a write strobe. A 32-bit frequency value goes into a staging pair in two 16-bit halves. Per-register enables then copy the staged value into the center or the offset register. Every control input is active low where it is an enable, and is registered before it acts, so it takes effect one clock after it is sampled. The phase word comes either from the host or from two external quadrant bits. Further controls mask the offset, break the accumulator feedback, add a carry of one, and fold the argument to half a cycle.

Top module: `nco_phase_ctrl`

## Requirements
- R1: After reset `acc_o` and `arg_o` are zero, and the center, offset and phase registers hold zero.
- R2: A host word is captured on the first clock where `host_wr_i` is sampled high after being low, only while `host_cs_ni` is low. Address 0 is the phase word, 1 is the low half of the staged frequency and 2 is the high half. Address 3 and strobes with chip select high change nothing.
- R3: Every control input is registered. A register enable sampled low at clock edge k loads its register at edge k+1.
- R4: While the registered accumulator enable is low, the accumulator adds the frequency sum every clock. Otherwise it holds its value.
- R5: While the registered clear-offset input is low, the offset contributes zero to the frequency sum. The stored offset is kept, and it can still be loaded during that time.
- R6: While the registered load input is low, the accumulator feedback is zero. The accumulator then takes the value of the frequency sum (plus carry).
- R7: While the registered carry input is low, each accumulate adds one more.
- R8: The phase register loads the host phase word when the registered source select is high. When it is low, it loads `{quad_i, 14'b0}`, giving a quadrant offset of 0, 90, 180 or 270 degrees for codes 0 to 3.
- R9: `arg_o` is updated each clock to the phase register plus the upper 16 bits of the accumulator, modulo 2^16.
- R10: While the registered half-wrap input is high, bit 15 of `arg_o` is forced to zero.
- R11: The accumulator wraps modulo 2^32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| host_cs_ni | input | 1 | Host chip select, active low |
| host_wr_i | input | 1 | Host write strobe, captured on its rising edge |
| host_addr_i | input | 2 | Host destination address |
| host_data_i | input | 16 | Host write data |
| en_phase_ni | input | 1 | Phase register load enable, active low |
| en_ofs_ni | input | 1 | Offset register load enable, active low |
| en_ctr_ni | input | 1 | Center register load enable, active low |
| en_acc_ni | input | 1 | Accumulator enable, active low |
| clr_ofs_ni | input | 1 | Offset path clear, active low |
| acc_load_ni | input | 1 | Accumulator feedback zero, active low |
| carry_ni | input | 1 | Accumulator carry-in, active low |
| pm_host_i | input | 1 | Phase source select: 1 host word, 0 quadrant bits |
| quad_i | input | 2 | Quadrant phase modulation bits |
| half_wrap_i | input | 1 | Fold argument to half a cycle |
| arg_o | output | 16 | Registered sine/cosine argument |
| acc_o | output | 32 | Phase accumulator value |

## Verification
Each frequency or phase register is visible only through what it adds, so a wrong stored word appears as a wrong step on `acc_o`. That step shows two clocks after the accumulator enable is sampled, and a wrong phase word shows in `arg_o` one clock after the accumulator or phase register settles. An off-by-one in the enable pipeline moves every accumulation count by exactly one step, so checks of the exact count after a fixed number of clocks catch it. A gating fault in clear, load or carry changes the accumulated value by a known amount within the same window.

// File: rtl/nco_pkg.sv
package nco_pkg;
  typedef struct packed {
    logic       en_phase;
    logic       en_ofs;
    logic       en_ctr;
    logic       en_acc;
    logic       ofs_on;
    logic       feedback_on;
    logic       carry;
    logic       pm_host;
    logic [1:0] quad;
    logic       half_wrap;
  } nco_ctl_t;

  localparam nco_ctl_t CTL_RESET = '{
    en_phase: 1'b0, en_ofs: 1'b0, en_ctr: 1'b0, en_acc: 1'b0,
    ofs_on: 1'b1, feedback_on: 1'b1, carry: 1'b0, pm_host: 1'b1,
    quad: 2'b00, half_wrap: 1'b0
  };
endpackage

// File: rtl/nco_host_regs.sv
module nco_host_regs #(
  parameter int DATA_W     = 16,
  parameter int ADDR_W     = 2,
  parameter int NUM_HALVES = 2,
  localparam int STAGE_W   = DATA_W * NUM_HALVES
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_ni,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [DATA_W-1:0] phase_word_o,
  output logic [STAGE_W-1:0] stage_o
);
  logic wr_q;
  logic strobe;

  assign strobe = wr_i & ~wr_q & ~cs_ni;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) wr_q <= 1'b0;
    else         wr_q <= wr_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                               phase_word_o <= '0;
    else if (strobe && addr_i == ADDR_W'(0))   phase_word_o <= data_i;
  end

  // address h+1 holds frequency half h, low half first
  for (genvar h = 0; h < NUM_HALVES; h++) begin : g_half
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                 stage_o[h*DATA_W +: DATA_W] <= '0;
      else if (strobe && addr_i == ADDR_W'(h + 1)) stage_o[h*DATA_W +: DATA_W] <= data_i;
    end
  end
endmodule

// File: rtl/nco_ctl_sync.sv
module nco_ctl_sync
  import nco_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  nco_ctl_t ctl_i,
  output nco_ctl_t ctl_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ctl_o <= CTL_RESET;
    else         ctl_o <= ctl_i;
  end
endmodule

// File: rtl/nco_freq_path.sv
module nco_freq_path #(
  parameter int ACC_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_ctr_i,
  input  logic             en_ofs_i,
  input  logic             en_acc_i,
  input  logic             ofs_on_i,
  input  logic             feedback_on_i,
  input  logic             carry_i,
  input  logic [ACC_W-1:0] stage_i,
  output logic [ACC_W-1:0] ofs_word_o,
  output logic [ACC_W-1:0] freq_sum_o,
  output logic [ACC_W-1:0] acc_o
);
  logic [ACC_W-1:0] ctr_q;
  logic [ACC_W-1:0] acc_fb;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       ctr_q <= '0;
    else if (en_ctr_i) ctr_q <= stage_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       ofs_word_o <= '0;
    else if (en_ofs_i) ofs_word_o <= stage_i;
  end

  assign freq_sum_o = ctr_q + (ofs_on_i ? ofs_word_o : '0);
  assign acc_fb     = feedback_on_i ? acc_o : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       acc_o <= '0;
    else if (en_acc_i) acc_o <= acc_fb + freq_sum_o + ACC_W'(carry_i);
  end
endmodule

// File: rtl/nco_phase_path.sv
module nco_phase_path #(
  parameter int PH_W   = 16,
  parameter int QUAD_W = 2,
  localparam int LOW_W = PH_W - QUAD_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_phase_i,
  input  logic              pm_host_i,
  input  logic [QUAD_W-1:0] quad_i,
  input  logic              half_wrap_i,
  input  logic [PH_W-1:0]   host_word_i,
  input  logic [PH_W-1:0]   acc_hi_i,
  output logic [PH_W-1:0]   phase_word_o,
  output logic [PH_W-1:0]   arg_o
);
  logic [PH_W-1:0] ph_src;
  logic [PH_W-1:0] arg_d;

  assign ph_src = pm_host_i ? host_word_i : {quad_i, {LOW_W{1'b0}}};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         phase_word_o <= '0;
    else if (en_phase_i) phase_word_o <= ph_src;
  end

  always_comb begin
    arg_d = phase_word_o + acc_hi_i;
    if (half_wrap_i) arg_d[PH_W-1] = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) arg_o <= '0;
    else         arg_o <= arg_d;
  end
endmodule

// File: rtl/nco_phase_ctrl.sv
module nco_phase_ctrl
  import nco_pkg::*;
#(
  parameter int ACC_W  = 32,
  parameter int DATA_W = 16,
  parameter int ADDR_W = 2,
  parameter int PH_W   = 16,
  parameter int QUAD_W = 2,
  localparam int NUM_HALVES = ACC_W / DATA_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              host_cs_ni,
  input  logic              host_wr_i,
  input  logic [ADDR_W-1:0] host_addr_i,
  input  logic [DATA_W-1:0] host_data_i,
  input  logic              en_phase_ni,
  input  logic              en_ofs_ni,
  input  logic              en_ctr_ni,
  input  logic              en_acc_ni,
  input  logic              clr_ofs_ni,
  input  logic              acc_load_ni,
  input  logic              carry_ni,
  input  logic              pm_host_i,
  input  logic [QUAD_W-1:0] quad_i,
  input  logic              half_wrap_i,
  output logic [PH_W-1:0]   arg_o,
  output logic [ACC_W-1:0]  acc_o
);
  nco_ctl_t         ctl_d, ctl_q;
  logic [PH_W-1:0]  host_phase;
  logic [ACC_W-1:0] stage_word;
  logic [ACC_W-1:0] ofs_word;
  logic [ACC_W-1:0] freq_sum;
  logic [PH_W-1:0]  phase_word;

  always_comb begin
    ctl_d.en_phase    = ~en_phase_ni;
    ctl_d.en_ofs      = ~en_ofs_ni;
    ctl_d.en_ctr      = ~en_ctr_ni;
    ctl_d.en_acc      = ~en_acc_ni;
    ctl_d.ofs_on      = clr_ofs_ni;
    ctl_d.feedback_on = acc_load_ni;
    ctl_d.carry       = ~carry_ni;
    ctl_d.pm_host     = pm_host_i;
    ctl_d.quad        = quad_i;
    ctl_d.half_wrap   = half_wrap_i;
  end

  nco_ctl_sync i_ctl_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .ctl_i (ctl_d),
    .ctl_o (ctl_q)
  );

  nco_host_regs #(
    .DATA_W    (DATA_W),
    .ADDR_W    (ADDR_W),
    .NUM_HALVES(NUM_HALVES)
  ) i_host_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cs_ni       (host_cs_ni),
    .wr_i        (host_wr_i),
    .addr_i      (host_addr_i),
    .data_i      (host_data_i),
    .phase_word_o(host_phase),
    .stage_o     (stage_word)
  );

  nco_freq_path #(.ACC_W(ACC_W)) i_freq_path (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .en_ctr_i     (ctl_q.en_ctr),
    .en_ofs_i     (ctl_q.en_ofs),
    .en_acc_i     (ctl_q.en_acc),
    .ofs_on_i     (ctl_q.ofs_on),
    .feedback_on_i(ctl_q.feedback_on),
    .carry_i      (ctl_q.carry),
    .stage_i      (stage_word),
    .ofs_word_o   (ofs_word),
    .freq_sum_o   (freq_sum),
    .acc_o        (acc_o)
  );

  nco_phase_path #(.PH_W(PH_W), .QUAD_W(QUAD_W)) i_phase_path (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .en_phase_i  (ctl_q.en_phase),
    .pm_host_i   (ctl_q.pm_host),
    .quad_i      (ctl_q.quad),
    .half_wrap_i (ctl_q.half_wrap),
    .host_word_i (host_phase),
    .acc_hi_i    (acc_o[ACC_W-1 -: PH_W]),
    .phase_word_o(phase_word),
    .arg_o       (arg_o)
  );
endmodule

// File: rtl/nco_phase_ctrl_chk.sv
module nco_phase_ctrl_chk #(
  parameter int ACC_W  = 32,
  parameter int PH_W   = 16,
  parameter int QUAD_W = 2
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             host_cs_ni,
  input logic             en_phase_ni,
  input logic             en_ofs_ni,
  input logic             en_acc_ni,
  input logic             clr_ofs_ni,
  input logic             acc_load_ni,
  input logic             carry_ni,
  input logic             pm_host_i,
  input logic             half_wrap_i,
  input logic [PH_W-1:0]  arg_i,
  input logic [ACC_W-1:0] acc_i,
  input logic [ACC_W-1:0] stage_i,
  input logic [ACC_W-1:0] ofs_word_i,
  input logic [ACC_W-1:0] freq_sum_i,
  input logic [PH_W-1:0]  phase_word_i
);
  AST_CS_IGNORE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    host_cs_ni |=> $stable(stage_i)); // R2

  AST_ACC_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(en_acc_ni) |=> $stable(acc_i)); // R4

  AST_OFS_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$past(clr_ofs_ni) && $past(en_ofs_ni)) |=> $stable(ofs_word_i)); // R5

  AST_LOAD_SUM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$past(en_acc_ni) && !$past(acc_load_ni) && $past(carry_ni))
      |=> acc_i == $past(freq_sum_i)); // R6

  AST_CARRY_ADD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$past(en_acc_ni) && $past(acc_load_ni) && !$past(carry_ni))
      |=> acc_i == $past(acc_i) + $past(freq_sum_i) + ACC_W'(1)); // R7

  AST_QUAD_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$past(en_phase_ni) && !$past(pm_host_i))
      |=> phase_word_i[PH_W-QUAD_W-1:0] == '0); // R8

  AST_ARG_SUM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(half_wrap_i)
      |=> arg_i == PH_W'($past(phase_word_i) + $past(acc_i[ACC_W-1 -: PH_W]))); // R9

  AST_HALF_MSB: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(half_wrap_i) |=> !arg_i[PH_W-1]); // R10
endmodule

bind nco_phase_ctrl nco_phase_ctrl_chk #(
  .ACC_W(ACC_W), .PH_W(PH_W), .QUAD_W(QUAD_W)
) i_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .host_cs_ni  (host_cs_ni),
  .en_phase_ni (en_phase_ni),
  .en_ofs_ni   (en_ofs_ni),
  .en_acc_ni   (en_acc_ni),
  .clr_ofs_ni  (clr_ofs_ni),
  .acc_load_ni (acc_load_ni),
  .carry_ni    (carry_ni),
  .pm_host_i   (pm_host_i),
  .half_wrap_i (half_wrap_i),
  .arg_i       (arg_o),
  .acc_i       (acc_o),
  .stage_i     (stage_word),
  .ofs_word_i  (ofs_word),
  .freq_sum_i  (freq_sum),
  .phase_word_i(phase_word)
);

// File: tb/test_nco_phase_ctrl.sv
module test_nco_phase_ctrl;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        host_cs_ni = 1'b1;
  logic        host_wr_i = 1'b0;
  logic [1:0]  host_addr_i = '0;
  logic [15:0] host_data_i = '0;
  logic        en_phase_ni = 1'b1;
  logic        en_ofs_ni = 1'b1;
  logic        en_ctr_ni = 1'b1;
  logic        en_acc_ni = 1'b1;
  logic        clr_ofs_ni = 1'b1;
  logic        acc_load_ni = 1'b1;
  logic        carry_ni = 1'b1;
  logic        pm_host_i = 1'b1;
  logic [1:0]  quad_i = '0;
  logic        half_wrap_i = 1'b0;
  logic [15:0] arg_o;
  logic [31:0] acc_o;

  int checks = 0;
  int errors = 0;

  always #5 clk_i = ~clk_i;

  nco_phase_ctrl i_nco_phase_ctrl (.*);

  task automatic tick();
    @(posedge clk_i);
    @(negedge clk_i);
  endtask

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_ni = 1'b0;
    host_cs_ni = 1'b1; host_wr_i = 1'b0; host_addr_i = '0; host_data_i = '0;
    en_phase_ni = 1'b1; en_ofs_ni = 1'b1; en_ctr_ni = 1'b1; en_acc_ni = 1'b1;
    clr_ofs_ni = 1'b1; acc_load_ni = 1'b1; carry_ni = 1'b1;
    pm_host_i = 1'b1; quad_i = '0; half_wrap_i = 1'b0;
    tick(); tick();
    rst_ni = 1'b1;
    tick();
  endtask

  task automatic host_write(logic [1:0] addr, logic [15:0] data, logic cs_n);
    host_cs_ni = cs_n; host_addr_i = addr; host_data_i = data; host_wr_i = 1'b0;
    tick();
    host_wr_i = 1'b1;
    tick();
    host_wr_i = 1'b0; host_cs_ni = 1'b1;
    tick();
  endtask

  // which: 0 center, 1 offset
  task automatic load_freq(bit which, logic [31:0] val);
    host_write(2'd1, val[15:0], 1'b0);
    host_write(2'd2, val[31:16], 1'b0);
    if (which) en_ofs_ni = 1'b0; else en_ctr_ni = 1'b0;
    tick();
    en_ofs_ni = 1'b1; en_ctr_ni = 1'b1;
    tick();
  endtask

  // exactly n accumulate steps; load/carry active for every step
  task automatic run_acc(int n, bit use_load, bit use_carry);
    en_acc_ni = 1'b0; acc_load_ni = ~use_load; carry_ni = ~use_carry;
    repeat (n) tick();
    en_acc_ni = 1'b1; acc_load_ni = 1'b1; carry_ni = 1'b1;
    tick();
  endtask

  task automatic load_phase();
    en_phase_ni = 1'b0;
    tick();
    en_phase_ni = 1'b1;
    tick();
  endtask

  task automatic t_reset();
    do_reset();
    check("R1 acc", acc_o, 32'h0);
    check("R1 arg", {16'h0, arg_o}, 32'h0);
    run_acc(3, 0, 0);
    check("R1 center zero", acc_o, 32'h0);
  endtask

  task automatic t_host_bus();
    do_reset();
    host_write(2'd1, 16'h1234, 1'b1);
    host_write(2'd2, 16'h0001, 1'b1);
    host_write(2'd3, 16'hFFFF, 1'b0);
    en_ctr_ni = 1'b0; tick(); en_ctr_ni = 1'b1; tick();
    run_acc(1, 0, 0);
    check("R2 cs high ignored", acc_o, 32'h0);
    host_write(2'd1, 16'h0003, 1'b0);
    host_write(2'd2, 16'h0002, 1'b0);
    host_write(2'd3, 16'hFFFF, 1'b0);
    en_ctr_ni = 1'b0; tick(); en_ctr_ni = 1'b1; tick();
    run_acc(1, 0, 0);
    check("R2 halves", acc_o, 32'h0002_0003);
  endtask

  task automatic t_latency();
    do_reset();
    load_freq(0, 32'h0001_0000);
    en_acc_ni = 1'b0;
    tick();
    check("R3 enable latency", acc_o, 32'h0);
    tick();
    check("R4 first step", acc_o, 32'h0001_0000);
    en_acc_ni = 1'b1;
    tick();
    check("R4 last step", acc_o, 32'h0002_0000);
    tick(); tick();
    check("R4 hold", acc_o, 32'h0002_0000);
    check("R9 arg from acc", {16'h0, arg_o}, 32'h0002);
  endtask

  task automatic t_offset_clear();
    do_reset();
    load_freq(0, 32'h0000_0100);
    clr_ofs_ni = 1'b0;
    tick();
    load_freq(1, 32'h0000_0020);
    run_acc(2, 0, 0);
    check("R5 offset masked", acc_o, 32'h0000_0200);
    clr_ofs_ni = 1'b1;
    tick();
    run_acc(1, 0, 0);
    check("R5 offset kept", acc_o, 32'h0000_0320);
  endtask

  task automatic t_load();
    do_reset();
    load_freq(0, 32'h0000_1000);
    run_acc(3, 0, 0);
    check("R4 three steps", acc_o, 32'h0000_3000);
    run_acc(2, 1, 0);
    check("R6 feedback zero", acc_o, 32'h0000_1000);
  endtask

  task automatic t_carry();
    do_reset();
    load_freq(0, 32'h0000_0010);
    run_acc(2, 0, 1);
    check("R7 carry", acc_o, 32'h0000_0022);
    run_acc(1, 1, 1);
    check("R7 carry with load", acc_o, 32'h0000_0011);
  endtask

  task automatic t_wrap();
    do_reset();
    load_freq(0, 32'hFFFF_FFFF);
    run_acc(2, 0, 0);
    check("R11 wrap", acc_o, 32'hFFFF_FFFE);
    run_acc(1, 0, 1);
    check("R11 wrap carry", acc_o, 32'hFFFF_FFFE);
  endtask

  task automatic t_phase();
    do_reset();
    host_write(2'd0, 16'h1234, 1'b0);
    pm_host_i = 1'b1;
    load_phase();
    tick();
    check("R8 host phase", {16'h0, arg_o}, 32'h1234);
    load_freq(0, 32'h0005_0000);
    run_acc(1, 0, 0);
    tick();
    check("R9 phase plus acc", {16'h0, arg_o}, 32'h1239);
    pm_host_i = 1'b0; quad_i = 2'd2;
    load_phase();
    tick();
    check("R8 quadrant 2", {16'h0, arg_o}, 32'h8005);
    quad_i = 2'd3;
    load_phase();
    tick();
    check("R8 quadrant 3", {16'h0, arg_o}, 32'hC005);
    half_wrap_i = 1'b1;
    tick(); tick();
    check("R10 half wrap", {16'h0, arg_o}, 32'h4005);
    half_wrap_i = 1'b0;
    tick(); tick();
    check("R10 full wrap", {16'h0, arg_o}, 32'hC005);
    load_freq(0, 32'h4000_0000);
    run_acc(1, 0, 0);
    tick();
    check("R9 mod 2^16", {16'h0, arg_o}, 32'h0005);
  endtask

  initial begin
    t_reset();
    t_host_bus();
    t_latency();
    t_offset_clear();
    t_load();
    t_carry();
    t_wrap();
    t_phase();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule